// File: doc/BRIEF.md
# LPC Host Cycle Decoder

This block sits on the target side of a low pin count host bus. It watches the frame strobe (active low) and the 4-bit multiplexed nibble bus. From each transaction header it works out what kind of access the host is making. It collects the address nibbles and, for writes, the data nibbles. It then hands a single-cycle request to a back end, giving the access kind, the direction, the address, the transfer size and any write data.

Once the host phase is over, the block runs the target half of the handshake for IO, memory and firmware memory accesses. That half is a turnaround with the bus released, a ready sync nibble, the read data when the access is a read, and a closing turnaround. A frame strobe seen at any point restarts decoding. The block ignores headers it does not serve, including unknown start codes and DMA types, and stays off the bus until the next frame.

Top module: `lpc_cycle_decoder`

## Requirements
- R1: The start code is the nibble bus value on the last clock on which `lframe_n` is sampled low. The header nibble is the value on the first clock after `lframe_n` returns high.
- R2: After start code 0x0, header bits [3:1] select the access: 000 IO read, 001 IO write, 010 memory read, 011 memory write. Header bit 0 has no effect, so headers 0x1/0x3/0x5/0x7 decode like 0x0/0x2/0x4/0x6.
- R3: An IO access takes 4 address nibbles and a memory access takes 8, both most significant nibble first. An IO address appears on `req_addr[15:0]` with the upper bits zero.
- R4: Start code 0xD is a firmware memory read and 0xE a firmware memory write. For these, the header nibble is a select nibble that is discarded. It is followed by 7 address nibbles, most significant first, which fill `req_addr[27:0]`, and then a size nibble: 0x0 means 8-bit, 0x1 means 16-bit, and any other value drops the access.
- R5: Write data arrives least significant nibble first: 2 nibbles for an 8-bit access and 4 for a 16-bit access. It is presented on `req_wdata`, with unused upper bits zero.
- R6: `req_valid` is high for exactly one cycle. That cycle is the one that follows the clock edge sampling the final host nibble. During it, `req_kind` reads 0 for IO, 1 for memory and 3 for firmware memory. `req_write` is 1 for writes. `req_size` reads 0 for 8-bit and 1 for 16-bit, and IO and memory accesses are always 8-bit.
- R7: The turnaround lasts two cycles, starting with the `req_valid` cycle, and `lad_oe` stays low throughout. In the next cycle the block drives sync 0x0 with `lad_oe` high.
- R8: For a read, `rd_data` is sampled on the edge that ends the turnaround. The block then drives 2 or 4 data nibbles, least significant first, follows them with two cycles with `lad_oe` low, and goes idle.
- R9: For a write, the sync cycle is followed by two cycles with `lad_oe` low, after which the block is idle.
- R10: The block issues no request and never raises `lad_oe` until the next `lframe_n` low in any of these cases: a start code other than 0x0/0xD/0xE, a DMA header (0x8–0xB), a reserved header (0xC–0xF), or a bad firmware size nibble.
- R11: `lframe_n` low during a host phase drops the partial access with no request, and decoding restarts from the new start code.
- R12: While reset is asserted and until it is released, `req_valid` and `lad_oe` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lframe_n | input | 1 | Frame strobe, active low |
| lad_in | input | 4 | Nibble bus as seen by the target |
| rd_data | input | 16 | Read data from the back end |
| lad_out | output | 4 | Nibble the target drives |
| lad_oe | output | 1 | Drive enable for `lad_out` |
| req_valid | output | 1 | One-cycle request strobe |
| req_kind | output | 2 | 0 IO, 1 memory, 3 firmware memory |
| req_write | output | 1 | 1 for a write access |
| req_addr | output | 32 | Decoded address |
| req_size | output | 2 | 0 for 8-bit, 1 for 16-bit |
| req_wdata | output | 16 | Collected write data |

## Verification
The hardest situations to reach from the ports are a strobe that falls partway through an address, and a strobe held low across several clocks with a different nibble on each. In both, stale header state could leak into the next access. The stimulus covers the first by cutting an IO write off after two address nibbles and following it at once with a complete read. It covers the second by holding the strobe low over three clocks with start codes 0x5, 0xF and 0x0 in turn. In both cases the bench's cycle model expects the bus to stay silent and no request to appear until the fresh access completes.

// File: rtl/lpcd_pkg.sv
package lpcd_pkg;

  typedef enum logic [1:0] {
    KIND_IO  = 2'd0,
    KIND_MEM = 2'd1,
    KIND_DMA = 2'd2,
    KIND_FW  = 2'd3
  } lpcd_kind_e;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_START,
    ST_ADDR,
    ST_FWSZ,
    ST_WDAT,
    ST_TARH,
    ST_SYNC,
    ST_RDAT,
    ST_TART
  } lpcd_state_e;

  typedef struct packed {
    logic       valid;
    lpcd_kind_e kind;
    logic       write;
    logic [3:0] nibs;
  } lpcd_hdr_t;

  localparam logic [3:0] START_NORMAL = 4'h0;
  localparam logic [3:0] START_FW_RD  = 4'hD;
  localparam logic [3:0] START_FW_WR  = 4'hE;

  localparam logic [3:0] NIB_IO  = 4'd4;
  localparam logic [3:0] NIB_MEM = 4'd8;
  localparam logic [3:0] NIB_FW  = 4'd7;

  localparam logic [3:0] SYNC_READY = 4'h0;

endpackage

// File: rtl/lpcd_hdr_dec.sv
module lpcd_hdr_dec
  import lpcd_pkg::*;
(
  input  logic [3:0] start_code,
  input  logic [2:0] type_bits,
  output lpcd_hdr_t  hdr
);

  always_comb begin
    hdr = '0;
    unique case (start_code)
      START_NORMAL: begin
        unique case (type_bits)
          3'd0: begin hdr.valid = 1'b1; hdr.kind = KIND_IO;  hdr.write = 1'b0; hdr.nibs = NIB_IO;  end
          3'd1: begin hdr.valid = 1'b1; hdr.kind = KIND_IO;  hdr.write = 1'b1; hdr.nibs = NIB_IO;  end
          3'd2: begin hdr.valid = 1'b1; hdr.kind = KIND_MEM; hdr.write = 1'b0; hdr.nibs = NIB_MEM; end
          3'd3: begin hdr.valid = 1'b1; hdr.kind = KIND_MEM; hdr.write = 1'b1; hdr.nibs = NIB_MEM; end
          3'd4, 3'd5: begin hdr.valid = 1'b0; hdr.kind = KIND_DMA; end
          default: hdr.valid = 1'b0;
        endcase
      end
      START_FW_RD, START_FW_WR: begin
        hdr.valid = 1'b1;
        hdr.kind  = KIND_FW;
        hdr.write = (start_code == START_FW_WR);
        hdr.nibs  = NIB_FW;
      end
      default: hdr.valid = 1'b0;
    endcase
  end

endmodule

// File: rtl/lpcd_nib_collect.sv
module lpcd_nib_collect #(
  parameter int ADDR_W   = 32,
  parameter int DATA_NIB = 4,
  localparam int DATA_W  = DATA_NIB * 4,
  localparam int IDX_W   = $clog2(DATA_NIB)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              addr_shift,
  input  logic              data_wr,
  input  logic [IDX_W-1:0]  data_idx,
  input  logic [3:0]        nib,
  output logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] wdata
);

  logic [ADDR_W-1:0] addr_q, addr_n;
  logic [DATA_W-1:0] wdata_q, wdata_n;
  logic              en;

  assign en = clr | addr_shift | data_wr;

  always_comb begin
    addr_n  = addr_q;
    wdata_n = wdata_q;
    if (clr) begin
      addr_n  = '0;
      wdata_n = '0;
    end else begin
      if (addr_shift) addr_n = {addr_q[ADDR_W-5:0], nib};
      for (int i = 0; i < DATA_NIB; i++) begin
        if (data_wr && data_idx == IDX_W'(i)) wdata_n[i*4 +: 4] = nib;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (en) begin
      addr_q  <= addr_n;
      wdata_q <= wdata_n;
    end
  end

  assign addr  = addr_q;
  assign wdata = wdata_q;

endmodule

// File: rtl/lpcd_resp_drv.sv
module lpcd_resp_drv
  import lpcd_pkg::*;
#(
  parameter int DATA_NIB = 4,
  localparam int DATA_W  = DATA_NIB * 4,
  localparam int IDX_W   = $clog2(DATA_NIB)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_load,
  input  logic [DATA_W-1:0] rd_data,
  input  logic             drive_sync,
  input  logic             drive_data,
  input  logic [IDX_W-1:0] data_idx,
  output logic [3:0]       lad_out,
  output logic             lad_oe
);

  logic [DATA_W-1:0] rd_q;
  logic [3:0]        data_nib;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rd_q <= '0;
    else if (rd_load) rd_q <= rd_data;
  end

  always_comb begin
    data_nib = 4'h0;
    for (int i = 0; i < DATA_NIB; i++) begin
      if (data_idx == IDX_W'(i)) data_nib = rd_q[i*4 +: 4];
    end
  end

  always_comb begin
    lad_out = 4'h0;
    if (drive_sync)      lad_out = SYNC_READY;
    else if (drive_data) lad_out = data_nib;
  end

  assign lad_oe = drive_sync | drive_data;

endmodule

// File: rtl/lpc_cycle_decoder.sv
module lpc_cycle_decoder
  import lpcd_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int DATA_NIB = 4,
  parameter int TAR_CYC  = 2,
  localparam int DATA_W  = DATA_NIB * 4,
  localparam int IDX_W   = $clog2(DATA_NIB),
  localparam int CNT_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lframe_n,
  input  logic [3:0]        lad_in,
  input  logic [DATA_W-1:0] rd_data,
  output logic [3:0]        lad_out,
  output logic              lad_oe,
  output logic              req_valid,
  output logic [1:0]        req_kind,
  output logic              req_write,
  output logic [ADDR_W-1:0] req_addr,
  output logic [1:0]        req_size,
  output logic [DATA_W-1:0] req_wdata
);

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_i_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i_n = rst_sync_q[1];

  lpcd_state_e      state_q, state_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic [IDX_W-1:0] idx_q, idx_n;
  lpcd_kind_e       kind_q, kind_n;
  logic             write_q, write_n;
  logic             wide_q, wide_n;
  logic [3:0]       start_q, start_n;
  logic             req_q, req_n;

  logic             clr, addr_shift, data_wr, rd_load;
  logic [IDX_W-1:0] last_idx;
  lpcd_hdr_t        hdr;

  lpcd_hdr_dec u_hdr (
    .start_code (start_q),
    .type_bits  (lad_in[3:1]),
    .hdr        (hdr)
  );

  assign last_idx = wide_q ? IDX_W'(DATA_NIB - 1) : IDX_W'(1);

  always_comb begin
    state_n    = state_q;
    cnt_n      = cnt_q;
    idx_n      = idx_q;
    kind_n     = kind_q;
    write_n    = write_q;
    wide_n     = wide_q;
    start_n    = start_q;
    req_n      = 1'b0;
    clr        = 1'b0;
    addr_shift = 1'b0;
    data_wr    = 1'b0;
    rd_load    = 1'b0;
    if (!lframe_n) begin
      state_n = ST_START;
      start_n = lad_in;
      clr     = 1'b1;
    end else begin
      unique case (state_q)
        ST_IDLE: state_n = ST_IDLE;
        ST_START: begin
          if (hdr.valid) begin
            state_n = ST_ADDR;
            kind_n  = hdr.kind;
            write_n = hdr.write;
            cnt_n   = hdr.nibs;
            wide_n  = 1'b0;
            idx_n   = '0;
          end else begin
            state_n = ST_IDLE;
          end
        end
        ST_ADDR: begin
          addr_shift = 1'b1;
          cnt_n      = cnt_q - 1'b1;
          if (cnt_q == CNT_W'(1)) begin
            if (kind_q == KIND_FW) begin
              state_n = ST_FWSZ;
            end else if (write_q) begin
              state_n = ST_WDAT;
            end else begin
              req_n   = 1'b1;
              state_n = ST_TARH;
              cnt_n   = CNT_W'(TAR_CYC);
            end
          end
        end
        ST_FWSZ: begin
          if (lad_in == 4'h0 || lad_in == 4'h1) begin
            wide_n = lad_in[0];
            if (write_q) begin
              state_n = ST_WDAT;
            end else begin
              req_n   = 1'b1;
              state_n = ST_TARH;
              cnt_n   = CNT_W'(TAR_CYC);
            end
          end else begin
            state_n = ST_IDLE;
          end
        end
        ST_WDAT: begin
          data_wr = 1'b1;
          idx_n   = idx_q + 1'b1;
          if (idx_q == last_idx) begin
            req_n   = 1'b1;
            state_n = ST_TARH;
            cnt_n   = CNT_W'(TAR_CYC);
            idx_n   = '0;
          end
        end
        ST_TARH: begin
          cnt_n = cnt_q - 1'b1;
          if (cnt_q == CNT_W'(1)) begin
            rd_load = 1'b1;
            state_n = ST_SYNC;
          end
        end
        ST_SYNC: begin
          idx_n = '0;
          if (write_q) begin
            state_n = ST_TART;
            cnt_n   = CNT_W'(TAR_CYC);
          end else begin
            state_n = ST_RDAT;
          end
        end
        ST_RDAT: begin
          idx_n = idx_q + 1'b1;
          if (idx_q == last_idx) begin
            state_n = ST_TART;
            cnt_n   = CNT_W'(TAR_CYC);
            idx_n   = '0;
          end
        end
        ST_TART: begin
          cnt_n = cnt_q - 1'b1;
          if (cnt_q == CNT_W'(1)) state_n = ST_IDLE;
        end
        default: state_n = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      idx_q   <= '0;
      kind_q  <= KIND_IO;
      write_q <= 1'b0;
      wide_q  <= 1'b0;
      start_q <= 4'hF;
      req_q   <= 1'b0;
    end else begin
      state_q <= state_n;
      cnt_q   <= cnt_n;
      idx_q   <= idx_n;
      kind_q  <= kind_n;
      write_q <= write_n;
      wide_q  <= wide_n;
      start_q <= start_n;
      req_q   <= req_n;
    end
  end

  lpcd_nib_collect #(.ADDR_W(ADDR_W), .DATA_NIB(DATA_NIB)) u_collect (
    .clk        (clk),
    .rst_n      (rst_i_n),
    .clr        (clr),
    .addr_shift (addr_shift),
    .data_wr    (data_wr),
    .data_idx   (idx_q),
    .nib        (lad_in),
    .addr       (req_addr),
    .wdata      (req_wdata)
  );

  lpcd_resp_drv #(.DATA_NIB(DATA_NIB)) u_resp (
    .clk        (clk),
    .rst_n      (rst_i_n),
    .rd_load    (rd_load),
    .rd_data    (rd_data),
    .drive_sync (state_q == ST_SYNC),
    .drive_data (state_q == ST_RDAT),
    .data_idx   (idx_q),
    .lad_out    (lad_out),
    .lad_oe     (lad_oe)
  );

  assign req_valid = req_q;
  assign req_kind  = kind_q;
  assign req_write = write_q;
  assign req_size  = {1'b0, wide_q};

  AST_REQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_i_n)
    req_valid |=> !req_valid); // R6
  AST_TAR_RELEASED: assert property (@(posedge clk) disable iff (!rst_i_n)
    req_valid |-> !lad_oe); // R7
  AST_TAR_SECOND: assert property (@(posedge clk) disable iff (!rst_i_n)
    (req_valid && lframe_n) |=> !lad_oe); // R7
  AST_SYNC_FIRST: assert property (@(posedge clk) disable iff (!rst_i_n)
    $rose(lad_oe) |-> (lad_out == SYNC_READY)); // R7
  AST_ABORT_SILENT: assert property (@(posedge clk) disable iff (!rst_i_n)
    !lframe_n |=> (!req_valid && !lad_oe)); // R11
  AST_NO_DMA_REQ: assert property (@(posedge clk) disable iff (!rst_i_n)
    req_valid |-> (req_kind != KIND_DMA)); // R10
  AST_HOST_BYTE: assert property (@(posedge clk) disable iff (!rst_i_n)
    (req_valid && req_kind != KIND_FW) |-> (req_size == 2'b00)); // R6
  AST_IO_ADDR_HIGH: assert property (@(posedge clk) disable iff (!rst_i_n)
    (req_valid && req_kind == KIND_IO) |-> (req_addr[ADDR_W-1:16] == '0)); // R3

endmodule

// File: tb/lpc_cycle_decoder_bench.sv
module lpc_cycle_decoder_bench;

  logic        clk;
  logic        rst_n;
  logic        lframe_n;
  logic [3:0]  lad_in;
  logic [15:0] rd_data;
  logic [3:0]  lad_out;
  logic        lad_oe;
  logic        req_valid;
  logic [1:0]  req_kind;
  logic        req_write;
  logic [31:0] req_addr;
  logic [1:0]  req_size;
  logic [15:0] req_wdata;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  // expected request fields for the current access
  logic [1:0]  e_kind;
  logic        e_write;
  logic [31:0] e_addr;
  logic [1:0]  e_size;
  logic [15:0] e_wdata;
  logic [3:0]  hq[$];

  lpc_cycle_decoder u_lpc_cycle_decoder (
    .clk       (clk),
    .rst_n     (rst_n),
    .lframe_n  (lframe_n),
    .lad_in    (lad_in),
    .rd_data   (rd_data),
    .lad_out   (lad_out),
    .lad_oe    (lad_oe),
    .req_valid (req_valid),
    .req_kind  (req_kind),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_size  (req_size),
    .req_wdata (req_wdata)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  // drive one bus clock, then compare all outputs against the model
  task automatic step(input logic lf, input logic [3:0] d, input logic eo,
                      input logic [3:0] el, input logic er, input string rq);
    lframe_n = lf;
    lad_in   = d;
    @(negedge clk);
    chk(req_valid == er, rq, "req_valid", 32'(req_valid), 32'(er));
    chk(lad_oe == eo, rq, "lad_oe", 32'(lad_oe), 32'(eo));
    if (eo) chk(lad_out == el, rq, "lad_out", 32'(lad_out), 32'(el));
    if (er) begin
      chk(req_kind == e_kind, rq, "req_kind", 32'(req_kind), 32'(e_kind));
      chk(req_write == e_write, rq, "req_write", 32'(req_write), 32'(e_write));
      chk(req_addr == e_addr, rq, "req_addr", req_addr, e_addr);
      chk(req_size == e_size, rq, "req_size", 32'(req_size), 32'(e_size));
      if (e_write) chk(req_wdata == e_wdata, rq, "req_wdata", 32'(req_wdata), 32'(e_wdata));
    end
  endtask

  task automatic push_addr(input logic [31:0] a, input int n);
    for (int i = n - 1; i >= 0; i--) hq.push_back(a[i*4 +: 4]);
  endtask

  task automatic push_data(input logic [15:0] d, input int n);
    for (int i = 0; i < n; i++) hq.push_back(d[i*4 +: 4]);
  endtask

  // start clock, queued host nibbles, then the expected target phase
  task automatic run_txn(input logic [3:0] st, input bit issue, input bit rd,
                         input int nrd, input string rq);
    step(1'b0, st, 1'b0, 4'h0, 1'b0, rq);
    for (int i = 0; i < hq.size(); i++)
      step(1'b1, hq[i], 1'b0, 4'h0, issue && (i == hq.size() - 1), rq);
    hq.delete();
    if (issue) begin
      step(1'b1, 4'hF, 1'b0, 4'h0, 1'b0, "R7");
      step(1'b1, 4'hF, 1'b1, 4'h0, 1'b0, "R7");
      if (rd) for (int k = 0; k < nrd; k++)
        step(1'b1, 4'hF, 1'b1, rd_data[k*4 +: 4], 1'b0, "R8");
      step(1'b1, 4'hF, 1'b0, 4'h0, 1'b0, rd ? "R8" : "R9");
      step(1'b1, 4'hF, 1'b0, 4'h0, 1'b0, rd ? "R8" : "R9");
    end
    step(1'b1, 4'hF, 1'b0, 4'h0, 1'b0, rq);
    step(1'b1, 4'hF, 1'b0, 4'h0, 1'b0, rq);
  endtask

  initial begin
    rst_n    = 1'b0;
    lframe_n = 1'b1;
    lad_in   = 4'hF;
    rd_data  = 16'h0;
    repeat (3) @(negedge clk);
    // R12: quiet while in reset
    chk(!req_valid, "R12", "req_valid in reset", 32'(req_valid), 0);
    chk(!lad_oe, "R12", "lad_oe in reset", 32'(lad_oe), 0);
    rst_n = 1'b1;
    for (int i = 0; i < 4; i++) step(1'b1, 4'hF, 1'b0, 4'h0, 1'b0, "R12");

    // R2 R3 R8: IO read
    rd_data = 16'h005C;
    e_kind = 2'd0; e_write = 1'b0; e_addr = 32'h0000_12A4; e_size = 2'd0;
    hq.push_back(4'h0); push_addr(32'h12A4, 4);
    run_txn(4'h0, 1, 1, 2, "R3");

    // R2 (bit 0 ignored) R5 R9: IO write with header 0x3
    e_kind = 2'd0; e_write = 1'b1; e_addr = 32'h0000_BEEF; e_size = 2'd0; e_wdata = 16'h007A;
    hq.push_back(4'h3); push_addr(32'hBEEF, 4); push_data(16'h7A, 2);
    run_txn(4'h0, 1, 0, 0, "R2");

    // R3 R8: memory read with header 0x5
    rd_data = 16'h00E1;
    e_kind = 2'd1; e_write = 1'b0; e_addr = 32'h89AB_CDEF; e_size = 2'd0;
    hq.push_back(4'h5); push_addr(32'h89AB_CDEF, 8);
    run_txn(4'h0, 1, 1, 2, "R3");

    // R5 R6: memory write
    e_kind = 2'd1; e_write = 1'b1; e_addr = 32'h0000_1000; e_size = 2'd0; e_wdata = 16'h00C3;
    hq.push_back(4'h6); push_addr(32'h0000_1000, 8); push_data(16'hC3, 2);
    run_txn(4'h0, 1, 0, 0, "R6");

    // R4 R8: firmware read, 16-bit
    rd_data = 16'hA55A;
    e_kind = 2'd3; e_write = 1'b0; e_addr = 32'h0123_4567; e_size = 2'd1;
    hq.push_back(4'h2); push_addr(32'h0123_4567, 7); hq.push_back(4'h1);
    run_txn(4'hD, 1, 1, 4, "R4");

    // R4 R5: firmware write, 8-bit
    e_kind = 2'd3; e_write = 1'b1; e_addr = 32'h0FED_CBA9; e_size = 2'd0; e_wdata = 16'h003C;
    hq.push_back(4'h9); push_addr(32'h0FED_CBA9, 7); hq.push_back(4'h0); push_data(16'h3C, 2);
    run_txn(4'hE, 1, 0, 0, "R4");

    // R4 R5: firmware write, 16-bit
    e_kind = 2'd3; e_write = 1'b1; e_addr = 32'h0000_0042; e_size = 2'd1; e_wdata = 16'hD00D;
    hq.push_back(4'h0); push_addr(32'h42, 7); hq.push_back(4'h1); push_data(16'hD00D, 4);
    run_txn(4'hE, 1, 0, 0, "R5");

    // R10: bad firmware size nibble
    hq.push_back(4'h0); push_addr(32'h1, 7); hq.push_back(4'h5); push_data(16'h11, 2);
    run_txn(4'hD, 0, 0, 0, "R10");

    // R10: unknown start code
    hq.push_back(4'h0); push_addr(32'h1234, 4);
    run_txn(4'h5, 0, 0, 0, "R10");

    // R10: DMA header
    hq.push_back(4'h8); push_addr(32'h1234, 4);
    run_txn(4'h0, 0, 0, 0, "R10");

    // R10: reserved header
    hq.push_back(4'hC); push_addr(32'h1234, 4);
    run_txn(4'h0, 0, 0, 0, "R10");

    // R11: IO write cut off after two address nibbles, then a full IO read
    step(1'b0, 4'h0, 1'b0, 4'h0, 1'b0, "R11");
    step(1'b1, 4'h2, 1'b0, 4'h0, 1'b0, "R11");
    step(1'b1, 4'h1, 1'b0, 4'h0, 1'b0, "R11");
    step(1'b1, 4'h2, 1'b0, 4'h0, 1'b0, "R11");
    rd_data = 16'h0096;
    e_kind = 2'd0; e_write = 1'b0; e_addr = 32'h0000_0380; e_size = 2'd0;
    hq.push_back(4'h0); push_addr(32'h0380, 4);
    run_txn(4'h0, 1, 1, 2, "R11");

    // R1: strobe held low over three clocks, last start code wins
    step(1'b0, 4'h5, 1'b0, 4'h0, 1'b0, "R1");
    step(1'b0, 4'hF, 1'b0, 4'h0, 1'b0, "R1");
    e_kind = 2'd1; e_write = 1'b1; e_addr = 32'hFFFF_0001; e_size = 2'd0; e_wdata = 16'h0055;
    hq.push_back(4'h7); push_addr(32'hFFFF_0001, 8); push_data(16'h55, 2);
    run_txn(4'h0, 1, 0, 0, "R1");

    // R1: strobe held low ending in an unknown code
    step(1'b0, 4'h0, 1'b0, 4'h0, 1'b0, "R1");
    hq.push_back(4'h0); push_addr(32'h5555, 4);
    run_txn(4'h9, 0, 0, 0, "R1");

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog (all requirements) actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule